// File: doc/BRIEF.md
# Timestamp and Pulse Timer Unit

This unit keeps one wide free-running timestamp and builds every slower time base from it. A 56-bit counter advances once for each clock cycle in which the reference tick enable is high; the reference is nominally a 19.2 MHz crystal. Each coarse timestamp output is a right-shifted view of that counter, with its own programmable shift. Typical shifts are 14, giving roughly 853 us per count, and 24, giving roughly 874 ms per count.

The same reference tick also drives a programmable divider, which produces a common timer tick once every (value + 1) reference ticks. A value of 191 turns 19.2 MHz into 100 kHz. A bank of pulse generators counts these common ticks. Each generator emits a single-cycle pulse at a granularity picked by a 2-bit code, and the bank can be built with three or four generators.

Software programs the unit through a plain write port. To change the rate safely, it clears the divider enable, writes the new divide value, then sets the enable again.

Top module: `tst_top`

## Requirements
- R1: After reset the base and coarse timestamps read zero, the divider is disabled, all shifts and granularity codes are zero, and the common tick and every pulse output are low.
- R2: The base timestamp increments by exactly one on each clock edge where the reference tick enable is high, and holds otherwise.
- R3: Coarse timestamp i equals the base timestamp shifted right by the 6-bit shift written at address 2+i (data bits [5:0]).
- R4: A write to address 1 (data bits [15:0]) while the divider is disabled sets the divide value. Once the divider is enabled, the common tick pulses once every (value + 1) reference ticks.
- R5: Address 0 bit 0 is the divider enable. While it is clear, the divider count holds at zero and no common tick or generator pulse is produced. After it is set, the first common tick follows exactly (value + 1) reference ticks.
- R6: A write to the divide value while the enable is set is ignored, and the tick period is unchanged.
- R7: The granularity code for generator g sits at bits [2g+1:2g] of the register at address 4. Codes 0, 1, 2 and 3 give one single-cycle pulse per 1, 10, 100 and 1000 common ticks respectively.
- R8: Any write to the granularity register restarts every generator. The next common tick loads the new reload count without pulsing, so the first pulse comes on the (N+1)-th common tick after the write, where N is the tick count for the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick_i | input | 1 | Reference crystal tick enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 32 | Register write data |
| ts_base_o | output | 56 | Full-resolution timestamp |
| ts_coarse_o | output | 112 | Coarse timestamps, entry i at bits [56i+55:56i] |
| tmr_tick_o | output | 1 | Common timer tick |
| pulse_o | output | 3 | One pulse output per generator |

## Verification
The hardest case is a granularity restart. Its outcome depends on where the write falls relative to the common tick phase, and a tick already in flight at the write must not count. The stimulus writes the codes while the divider runs freely. The monitor counts only the common ticks seen from the write's capture cycle onward, ignores any pulse that cannot yet reflect the restart, and then checks the tick count before the first pulse and the spacing of the pulses after it. The disabled-divider window and the locked divide value are reached by writing in the order software would use, and the tick spacing is checked afterwards.

// File: rtl/tst_pkg.sv
package tst_pkg;

    typedef enum logic [1:0] {
        GRAN_10US  = 2'd0,
        GRAN_100US = 2'd1,
        GRAN_1MS   = 2'd2,
        GRAN_10MS  = 2'd3
    } gran_e;

    localparam int RELOAD_W       = 10;
    localparam int ADDR_DIV_EN    = 0;
    localparam int ADDR_DIV_VAL   = 1;
    localparam int ADDR_SHIFT_BASE = 2;

    // Reload is the tick count per period minus one.
    function automatic logic [RELOAD_W-1:0] gran_reload(gran_e g);
        case (g)
            GRAN_10US:  return RELOAD_W'(0);
            GRAN_100US: return RELOAD_W'(9);
            GRAN_1MS:   return RELOAD_W'(99);
            default:    return RELOAD_W'(999);
        endcase
    endfunction

endpackage

// File: rtl/tst_stamp.sv
module tst_stamp #(
    parameter int TS_W   = 56,
    parameter int NUM_TS = 2,
    parameter int SH_W   = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ref_tick_i,
    input  logic [NUM_TS-1:0]      sh_wr_i,
    input  logic [SH_W-1:0]        sh_data_i,
    output logic [TS_W-1:0]        base_o,
    output logic [NUM_TS*TS_W-1:0] coarse_o
);

    typedef struct packed {
        logic [TS_W-1:0]              cnt;
        logic [NUM_TS-1:0][SH_W-1:0]  sh;
    } stamp_t;

    stamp_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ref_tick_i) begin
            st_d.cnt = st_q.cnt + TS_W'(1);
        end
        for (int i = 0; i < NUM_TS; i++) begin
            if (sh_wr_i[i]) begin
                st_d.sh[i] = sh_data_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign base_o = st_q.cnt;

    for (genvar i = 0; i < NUM_TS; i++) begin : g_view
        assign coarse_o[i*TS_W +: TS_W] = st_q.cnt >> st_q.sh[i];
    end

    AST_TS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_tick_i |=> $stable(base_o)); // R2

endmodule

// File: rtl/tst_divider.sv
module tst_divider #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick_i,
    input  logic             en_wr_i,
    input  logic             en_data_i,
    input  logic             val_wr_i,
    input  logic [DIV_W-1:0] val_data_i,
    output logic             tick_o
);

    typedef struct packed {
        logic             en;
        logic [DIV_W-1:0] val;
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } div_t;

    div_t dv_d, dv_q;

    always_comb begin
        dv_d      = dv_q;
        dv_d.tick = 1'b0;
        if (en_wr_i) begin
            dv_d.en = en_data_i;
        end
        // Rate may change only while the divider is stopped.
        if (val_wr_i && !dv_q.en) begin
            dv_d.val = val_data_i;
        end
        if (!dv_q.en) begin
            dv_d.cnt = '0;
        end else if (ref_tick_i) begin
            if (dv_q.cnt == dv_q.val) begin
                dv_d.cnt  = '0;
                dv_d.tick = 1'b1;
            end else begin
                dv_d.cnt = dv_q.cnt + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dv_q <= '0;
        end else begin
            dv_q <= dv_d;
        end
    end

    assign tick_o = dv_q.tick;

    AST_OFF_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !dv_q.en |=> !tick_o); // R5

    AST_VAL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (dv_q.en && val_wr_i) |=> $stable(dv_q.val)); // R6

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        dv_q.en |-> (dv_q.cnt <= dv_q.val)); // R4

endmodule

// File: rtl/tst_pulse_gen.sv
module tst_pulse_gen
    import tst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       code_wr_i,
    input  logic [1:0] code_data_i,
    output logic       pulse_o
);

    typedef struct packed {
        gran_e               code;
        logic [RELOAD_W-1:0] cnt;
        logic                restart;
        logic                pulse;
    } pg_t;

    pg_t pg_d, pg_q;

    always_comb begin
        pg_d       = pg_q;
        pg_d.pulse = 1'b0;
        if (tick_i) begin
            if (pg_q.restart) begin
                pg_d.cnt     = gran_reload(pg_q.code);
                pg_d.restart = 1'b0;
            end else if (pg_q.cnt == '0) begin
                pg_d.pulse = 1'b1;
                pg_d.cnt   = gran_reload(pg_q.code);
            end else begin
                pg_d.cnt = pg_q.cnt - RELOAD_W'(1);
            end
        end
        if (code_wr_i) begin
            pg_d.code    = gran_e'(code_data_i);
            pg_d.restart = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pg_q <= '0;
        end else begin
            pg_q <= pg_d;
        end
    end

    assign pulse_o = pg_q.pulse;

    AST_PULSE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> $past(tick_i)); // R7

    AST_RESTART_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_q.restart && tick_i) |=> !pulse_o); // R8

endmodule

// File: rtl/tst_top.sv
module tst_top
    import tst_pkg::*;
#(
    parameter int TS_W   = 56,
    parameter int NUM_TS = 2,
    parameter int NUM_PG = 3,
    parameter int DIV_W  = 16,
    parameter int SH_W   = 6,
    parameter int AW     = 3,
    parameter int DW     = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ref_tick_i,
    input  logic                   wr_en_i,
    input  logic [AW-1:0]          wr_addr_i,
    input  logic [DW-1:0]          wr_data_i,
    output logic [TS_W-1:0]        ts_base_o,
    output logic [NUM_TS*TS_W-1:0] ts_coarse_o,
    output logic                   tmr_tick_o,
    output logic [NUM_PG-1:0]      pulse_o
);

    localparam int GRAN_ADDR = ADDR_SHIFT_BASE + NUM_TS;

    logic [NUM_TS-1:0] sh_wr;
    logic              en_wr;
    logic              val_wr;
    logic              gran_wr;
    logic              common_tick;
    logic              unused_hi;

    assign unused_hi = ^wr_data_i[DW-1:DIV_W];
    assign en_wr     = wr_en_i && (wr_addr_i == AW'(ADDR_DIV_EN));
    assign val_wr    = wr_en_i && (wr_addr_i == AW'(ADDR_DIV_VAL));
    assign gran_wr   = wr_en_i && (wr_addr_i == AW'(GRAN_ADDR));

    for (genvar i = 0; i < NUM_TS; i++) begin : g_shdec
        assign sh_wr[i] = wr_en_i && (wr_addr_i == AW'(ADDR_SHIFT_BASE + i));
    end

    tst_stamp #(
        .TS_W   (TS_W),
        .NUM_TS (NUM_TS),
        .SH_W   (SH_W)
    ) u_stamp (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick_i (ref_tick_i),
        .sh_wr_i    (sh_wr),
        .sh_data_i  (wr_data_i[SH_W-1:0]),
        .base_o     (ts_base_o),
        .coarse_o   (ts_coarse_o)
    );

    tst_divider #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick_i (ref_tick_i),
        .en_wr_i    (en_wr),
        .en_data_i  (wr_data_i[0]),
        .val_wr_i   (val_wr),
        .val_data_i (wr_data_i[DIV_W-1:0]),
        .tick_o     (common_tick)
    );

    assign tmr_tick_o = common_tick;

    for (genvar g = 0; g < NUM_PG; g++) begin : g_pg
        tst_pulse_gen u_pg (
            .clk         (clk),
            .rst_n       (rst_n),
            .tick_i      (common_tick),
            .code_wr_i   (gran_wr),
            .code_data_i (wr_data_i[2*g +: 2]),
            .pulse_o     (pulse_o[g])
        );
    end

endmodule

// File: tb/tst_top_tb.sv
module tst_top_tb;

    localparam int NPG = 3;
    localparam int TW  = 56;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ref_tick = 1'b0;
    logic           wr_en = 1'b0;
    logic [2:0]     wr_addr = '0;
    logic [31:0]    wr_data = '0;
    logic [TW-1:0]  ts_base;
    logic [2*TW-1:0] ts_coarse;
    logic           tmr_tick;
    logic [NPG-1:0] pulse;

    tst_top u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_tick_i  (ref_tick),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .ts_base_o   (ts_base),
        .ts_coarse_o (ts_coarse),
        .tmr_tick_o  (tmr_tick),
        .pulse_o     (pulse)
    );

    always #10 clk = ~clk;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    done = 1'b0;

    int    exp_tick_q[$];
    string tick_tag = "R4";
    int    last_tick = 0;
    bit    forbid = 1'b0;
    int    forbid_hits = 0;

    bit    armed [NPG];
    int    w_cyc [NPG];
    int    ticks_since [NPG];
    int    first_exp [NPG];
    int    int_exp [NPG];
    int    rem [NPG];
    int    last_p [NPG];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic enable_div(input bit e);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = {31'd0, e};
        last_tick = cyc + 1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Write granularity codes and push the expected restart behaviour.
    task automatic set_gran(input int c0, input int c1, input int c2, input int per, input int n);
        int cnt [NPG];
        cnt[0] = c0; cnt[1] = c1; cnt[2] = c2;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd4;
        wr_data = '0;
        for (int g = 0; g < NPG; g++) begin
            wr_data[2*g +: 2] = (cnt[g] == 1) ? 2'd0 : (cnt[g] == 10) ? 2'd1 :
                                (cnt[g] == 100) ? 2'd2 : 2'd3;
            armed[g]       = 1'b1;
            w_cyc[g]       = cyc + 1;
            ticks_since[g] = 0;
            first_exp[g]   = cnt[g] + 1;
            int_exp[g]     = cnt[g] * per;
            rem[g]         = n;
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Monitor: scoreboard consumer, samples a quarter period after the edge.
    always @(posedge clk) begin
        #5;
        if (rst_n) begin
            if (tmr_tick) begin
                if (forbid) forbid_hits++;
                else if (exp_tick_q.size() > 0) begin
                    int e;
                    e = exp_tick_q.pop_front();
                    chk((cyc - last_tick) == e, tick_tag, cyc - last_tick, e);
                end
                last_tick = cyc;
            end
            for (int g = 0; g < NPG; g++) begin
                if (pulse[g]) begin
                    if (forbid) forbid_hits++;
                    else if (armed[g]) begin
                        if (cyc > w_cyc[g]) begin
                            chk(ticks_since[g] == first_exp[g], "R8", ticks_since[g], first_exp[g]);
                            armed[g] = 1'b0;
                        end
                    end else if (rem[g] > 0) begin
                        chk((cyc - last_p[g]) == int_exp[g], "R7", cyc - last_p[g], int_exp[g]);
                        rem[g]--;
                    end
                    last_p[g] = cyc;
                end
                if (tmr_tick && armed[g] && cyc >= w_cyc[g]) ticks_since[g]++;
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            report();
        end
    end

    initial begin
        for (int g = 0; g < NPG; g++) begin
            armed[g] = 1'b0; w_cyc[g] = 0; ticks_since[g] = 0;
            first_exp[g] = 0; int_exp[g] = 0; rem[g] = 0; last_p[g] = 0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(ts_base == '0, "R1", ts_base, 0);
        chk(ts_coarse == '0, "R1", ts_coarse[55:0], 0);
        chk(tmr_tick == 1'b0, "R1", tmr_tick, 0);
        chk(pulse == '0, "R1", pulse, 0);

        // R2: count only on reference ticks
        ref_tick = 1'b1;
        repeat (37) @(negedge clk);
        ref_tick = 1'b0;
        repeat (10) @(negedge clk);
        chk(ts_base == 56'd37, "R2", ts_base, 37);
        for (int i = 0; i < 20; i++) begin
            ref_tick = (i % 2) == 1;
            @(negedge clk);
        end
        ref_tick = 1'b0;
        @(negedge clk);
        chk(ts_base == 56'd47, "R2", ts_base, 47);

        // R3: shifted views
        wr(3'd2, 32'd4);
        wr(3'd3, 32'd14);
        @(negedge clk);
        chk(ts_coarse[0 +: TW] == 56'd2, "R3", ts_coarse[0 +: TW], 2);
        chk(ts_coarse[TW +: TW] == 56'd0, "R3", ts_coarse[TW +: TW], 0);
        ref_tick = 1'b1;
        repeat (20000) @(negedge clk);
        ref_tick = 1'b0;
        @(negedge clk);
        chk(ts_base == 56'd20047, "R3", ts_base, 20047);
        chk(ts_coarse[0 +: TW] == 56'd1252, "R3", ts_coarse[0 +: TW], 1252);
        chk(ts_coarse[TW +: TW] == 56'd1, "R3", ts_coarse[TW +: TW], 1);

        // R4: divide by value+1, first tick counted from enable
        ref_tick = 1'b1;
        wr(3'd1, 32'd4);
        tick_tag = "R4";
        exp_tick_q.push_back(5); exp_tick_q.push_back(5); exp_tick_q.push_back(5);
        enable_div(1'b1);
        repeat (30) @(negedge clk);
        chk(exp_tick_q.size() == 0, "R4", exp_tick_q.size(), 0);

        // R6: value write while enabled is ignored
        wr(3'd1, 32'd9);
        tick_tag = "R6";
        exp_tick_q.push_back(5); exp_tick_q.push_back(5); exp_tick_q.push_back(5);
        repeat (30) @(negedge clk);
        chk(exp_tick_q.size() == 0, "R6", exp_tick_q.size(), 0);

        // R7/R8: granularities 10, 100, 1000 common ticks (5 cycles each)
        set_gran(10, 100, 1000, 5, 2);
        repeat (15100) @(negedge clk);
        for (int g = 0; g < NPG; g++) begin
            chk(!armed[g] && rem[g] == 0, "R8", rem[g] + int'(armed[g]), 0);
        end
        set_gran(1, 1, 1, 5, 3);
        repeat (60) @(negedge clk);
        for (int g = 0; g < NPG; g++) begin
            chk(!armed[g] && rem[g] == 0, "R7", rem[g] + int'(armed[g]), 0);
        end

        // R5: disabled divider produces nothing, restart counts from zero
        enable_div(1'b0);
        repeat (3) @(negedge clk);
        forbid = 1'b1;
        repeat (100) @(negedge clk);
        forbid = 1'b0;
        chk(forbid_hits == 0, "R5", forbid_hits, 0);
        wr(3'd1, 32'd9);
        tick_tag = "R5";
        exp_tick_q.push_back(10); exp_tick_q.push_back(10);
        enable_div(1'b1);
        repeat (40) @(negedge clk);
        chk(exp_tick_q.size() == 0, "R5", exp_tick_q.size(), 0);

        done = 1'b1;
        report();
    end

endmodule